// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block moves 8- or 16-bit frames over a three-wire synchronous serial link: a serial clock, a data output and a data input. As master it makes the serial clock itself by dividing the system clock. As slave it follows a clock that arrives from outside. Control inputs set the frame width, the bit order, receive-only or full-duplex operation, single or repeat operation, and an optional half-clock delay of the end-of-frame interrupt. Software-side access is reduced to a write strobe into a one-entry transmit buffer, a read strobe with the receive buffer value, a busy flag and a one-cycle interrupt pulse.

In full-duplex operation, writing the transmit buffer while the port is idle starts a frame. In receive-only operation, a read strobe on the receive buffer starts a frame, and the data output stays low. The enable input works as an asynchronous reset for the whole port. When it is low, every register returns to its reset value and a frame in flight is dropped.

Top module: `sync_serial_port`

## Requirements
- R1: While `en` is 0 the port is held in reset without waiting for a clock edge. `busy` and `irq` are 0, `rx_data` is 0, `sck_out` is 1 and `sdo` is 0.
- R2: With `full_duplex`=1, a `tx_wr` pulse while idle loads `tx_data` and starts a frame. `busy` reads 1 from the next cycle, and the frame's bits appear on `sdo`.
- R3: With `full_duplex`=0, an `rx_rd` pulse while idle starts a frame. `sdo` stays 0 for the whole frame.
- R4: `wide`=0 gives 8-bit frames and `wide`=1 gives 16-bit frames. After an 8-bit frame the received bits are in `rx_data[7:0]` and `rx_data[15:8]` reads 0.
- R5: `lsb_first`=0 sends and receives bit 7 (8-bit) or bit 15 (16-bit) first. `lsb_first`=1 sends and receives bit 0 first.
- R6: In master mode (`clk_sel` not 3'b111), `sck_out` idles high and each half period lasts 2^`clk_sel` system clocks. A new bit is driven on each falling edge and `sdi` is sampled on each rising edge. `irq` goes high 2·N·2^`clk_sel`+1 cycles after the start strobe is sampled, counted at the first falling system clock edge after the sampling edge as 1, where N is the frame width.
- R7: In master mode with `irq_delay`=1, `irq` comes 2^`clk_sel` cycles later than with `irq_delay`=0.
- R8: With `clk_sel`=3'b111 the port is a slave. It shifts `sdo` on falling edges of `sck_in` and samples on rising edges, and `sck_out` stays 1. `irq_delay` is ignored: `irq` rises in the cycle after the last rising `sck_in` edge is sampled.
- R9: `irq` is a one-cycle pulse, one per frame. In single mode `busy` falls in the same cycle that `irq` rises.
- R10: With `repeat_mode`=1 the next frame starts when the previous one ends, and `busy` stays 1. A full-duplex repeat frame sends the current transmit buffer contents. Clearing `repeat_mode` lets the running frame finish, and then the port goes idle.
- R11: A start strobe while `busy` is 1 does not restart or change the running frame. A `tx_wr` still updates the buffer used by later repeat frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable; 0 holds the port in reset |
| full_duplex | input | 1 | 1: transmit and receive, 0: receive only |
| wide | input | 1 | 0: 8-bit frames, 1: 16-bit frames |
| lsb_first | input | 1 | 1: least significant bit first |
| irq_delay | input | 1 | 1: delay end-of-frame interrupt by half a serial clock (master only) |
| repeat_mode | input | 1 | 1: frames follow one another automatically |
| clk_sel | input | 3 | Master clock divider select; 3'b111 selects slave mode |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 16 | Transmit buffer write data |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 16 | Receive buffer contents |
| busy | output | 1 | 1 while a frame is in progress |
| irq | output | 1 | One-cycle end-of-frame pulse |
| sck_in | input | 1 | Serial clock input (slave mode) |
| sck_out | output | 1 | Serial clock output (master mode) |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
The bound checker watches properties that must hold in every cycle. `sck_out` is high whenever the port is idle. `sdo` is low once receive-only operation has been selected. `irq` never lasts two cycles. `busy` never falls without `irq`. An 8-bit frame never leaves bits in the upper half of the receive buffer, and `sck_out` does not move in slave mode. Other properties are only visible from the bench's scenarios: the exact cycle the interrupt arrives at for each divider and delay setting, the bit order and width of the data on both wires, repeat frames that pick up a new buffer value, strobes ignored mid-frame, and the asynchronous reset through the enable.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int CSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           full_duplex,
  input  logic           wide,
  input  logic           lsb_first,
  input  logic           irq_delay,
  input  logic           repeat_mode,
  input  logic [CSW-1:0] clk_sel,
  input  logic           tx_wr,
  input  logic [15:0]    tx_data,
  input  logic           rx_rd,
  output logic [15:0]    rx_data,
  output logic           busy,
  output logic           irq,
  input  logic           sck_in,
  output logic           sck_out,
  input  logic           sdi,
  output logic           sdo
);
  localparam int DIVW = (1 << CSW) - 1;

  logic            arst_n;
  logic            slave;
  logic [DIVW-1:0] half_m1;
  logic [DIVW-1:0] div_q;
  logic            busy_q, sck_q, sck_in_q, sdo_q, irq_q, dly_q;
  logic [15:0]     sh_q, txb_q, rxb_q;
  logic [4:0]      cnt_q;
  logic            tick, fall_ev, rise_ev, start, frame_end, use_dly, finish, out_bit;
  logic [4:0]      last;
  logic [15:0]     sh_nx, load;

  assign arst_n    = rst_n & en;
  assign slave     = &clk_sel;
  assign half_m1   = (DIVW'(1) << clk_sel) - DIVW'(1);
  assign tick      = !slave && busy_q && (div_q == half_m1);
  assign fall_ev   = busy_q && !dly_q && (slave ? (sck_in_q && !sck_in) : (tick && sck_q));
  assign rise_ev   = busy_q && !dly_q && (slave ? (!sck_in_q && sck_in) : (tick && !sck_q));
  assign last      = wide ? 5'd15 : 5'd7;
  assign out_bit   = lsb_first ? sh_q[0] : (wide ? sh_q[15] : sh_q[7]);
  assign sh_nx     = lsb_first ? (wide ? {sdi, sh_q[15:1]} : {8'h00, sdi, sh_q[7:1]})
                               : {sh_q[14:0], sdi};
  assign start     = !busy_q && (full_duplex ? tx_wr : rx_rd);
  assign frame_end = rise_ev && (cnt_q == last);
  assign use_dly   = irq_delay && !slave;
  assign finish    = (frame_end && !use_dly) || (dly_q && tick);
  assign load      = full_duplex ? (start ? tx_data : txb_q) : 16'h0000;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      div_q    <= '0;
      busy_q   <= 1'b0;
      sck_q    <= 1'b1;
      sck_in_q <= 1'b1;
      sdo_q    <= 1'b0;
      irq_q    <= 1'b0;
      dly_q    <= 1'b0;
      sh_q     <= '0;
      txb_q    <= '0;
      rxb_q    <= '0;
      cnt_q    <= '0;
    end else begin
      sck_in_q <= sck_in;
      irq_q    <= finish;
      div_q    <= (!busy_q || tick) ? '0 : div_q + DIVW'(1);
      if (tx_wr) txb_q <= tx_data;
      if (!full_duplex) sdo_q <= 1'b0;
      else if (fall_ev) sdo_q <= out_bit;
      if (start) begin
        busy_q <= 1'b1;
        sh_q   <= load;
        cnt_q  <= '0;
        sck_q  <= 1'b1;
        dly_q  <= 1'b0;
      end else if (busy_q) begin
        if (tick && !dly_q) sck_q <= !sck_q;
        if (rise_ev) begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 5'd1;
        end
        if (frame_end) begin
          rxb_q <= wide ? sh_nx : {8'h00, sh_nx[7:0]};
          if (use_dly) dly_q <= 1'b1;
        end
        if (finish) begin
          dly_q <= 1'b0;
          if (repeat_mode) begin
            sh_q  <= load;
            cnt_q <= '0;
          end else begin
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign rx_data = rxb_q;
  assign busy    = busy_q;
  assign irq     = irq_q;
  assign sck_out = sck_q;
  assign sdo     = sdo_q;
endmodule

module sync_serial_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        full_duplex,
  input logic        wide,
  input logic [2:0]  clk_sel,
  input logic [15:0] rx_data,
  input logic        busy,
  input logic        irq,
  input logic        sck_out,
  input logic        sdo
);
  AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !en)
    !busy |-> sck_out); // R6
  AST_RXONLY_SDO_LOW: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $past(!full_duplex) |-> !sdo); // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !en)
    irq |=> !irq); // R9
  AST_BUSY_FALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $fell(busy) |-> irq); // R9
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (irq && $past(!wide)) |-> (rx_data[15:8] == 8'h00)); // R4
  AST_SLAVE_SCK_STILL: assert property (@(posedge clk) disable iff (!rst_n || !en)
    ((&clk_sel) && $past(&clk_sel) && $past(sck_out)) |-> sck_out); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $rose(busy) |-> !irq); // R2
endmodule

bind sync_serial_port sync_serial_port_chk chk (.*);

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, en = 1;
  logic full_duplex = 1, wide = 0, lsb_first = 0, irq_delay = 0, repeat_mode = 0;
  logic [2:0] clk_sel = 0;
  logic tx_wr = 0, rx_rd = 0;
  logic [15:0] tx_data = 0;
  logic [15:0] rx_data;
  logic busy, irq, sck_out, sdo;
  logic sck_in = 1, sdi_s = 0, sdi_m = 0, sdi;

  int total = 0, bad = 0;

  bit m_on = 0, m_lsb = 0, m_sdo_hi = 0;
  int m_len = 8, m_k = 0;
  logic [15:0] m_pat = 0, m_cap = 0, m_done = 0;

  assign sdi = m_on ? sdi_m : sdi_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .en(en), .full_duplex(full_duplex), .wide(wide),
    .lsb_first(lsb_first), .irq_delay(irq_delay), .repeat_mode(repeat_mode),
    .clk_sel(clk_sel), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .rx_data(rx_data), .busy(busy), .irq(irq), .sck_in(sck_in), .sck_out(sck_out),
    .sdi(sdi), .sdo(sdo));

  function automatic int bidx(int len, bit lsb, int k);
    return lsb ? k : len - 1 - k;
  endfunction

  function automatic logic [15:0] fmask(logic [15:0] v, bit w);
    return w ? v : {8'h00, v[7:0]};
  endfunction

  always @(negedge sck_out) if (m_on) sdi_m = m_pat[bidx(m_len, m_lsb, m_k)];

  always @(posedge sck_out) if (m_on) begin
    m_cap[bidx(m_len, m_lsb, m_k)] = sdo;
    if (sdo) m_sdo_hi = 1;
    if (m_k == m_len - 1) begin
      m_done = m_cap; m_cap = 0; m_k = 0;
    end else m_k = m_k + 1;
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_master(bit fd, bit w, bit lsb, int sel, bit dl,
                            logic [15:0] txd, logic [15:0] pat, bit mid_wr);
    int len = w ? 16 : 8;
    int h = 1 << sel;
    int n = 1;
    int exp_n = 2 * len * h + 1 + (dl ? h : 0);
    @(negedge clk);
    full_duplex = fd; wide = w; lsb_first = lsb; clk_sel = 3'(sel);
    irq_delay = dl; repeat_mode = 0;
    m_len = len; m_lsb = lsb; m_pat = pat; m_k = 0; m_cap = 0; m_sdo_hi = 0; m_on = 1;
    if (fd) begin tx_data = txd; tx_wr = 1; end else rx_rd = 1;
    @(negedge clk);
    tx_wr = 0; rx_rd = 0;
    check(busy === 1'b1, fd ? "R2 busy after write" : "R3 busy after read", busy, 1);
    while (irq !== 1'b1 && n < 20000) begin
      @(negedge clk); n++;
      if (mid_wr && n == 10) begin tx_data = ~txd; tx_wr = 1; rx_rd = 1; end
      if (mid_wr && n == 11) begin tx_wr = 0; rx_rd = 0; end
    end
    check(n == exp_n, dl ? "R7 delayed irq timing" : "R6 irq timing", n, exp_n);
    check(rx_data === fmask(pat, w), w ? "R5 rx data 16" : "R4 rx data 8 low byte",
          rx_data, fmask(pat, w));
    if (fd)
      check(m_done === fmask(txd, w), mid_wr ? "R11 frame unchanged" : "R2 sdo data",
            m_done, fmask(txd, w));
    else
      check(m_sdo_hi == 0 && m_done == 0, "R3 sdo held low", m_done, 0);
    @(negedge clk);
    check(irq === 1'b0 && busy === 1'b0, "R9 single pulse and idle", {irq, busy}, 0);
    m_on = 0;
  endtask

  task automatic run_slave(bit fd, bit w, bit lsb, logic [15:0] txd, logic [15:0] pat);
    int len = w ? 16 : 8;
    logic [15:0] cap = 0;
    bit sck_moved = 0;
    @(negedge clk);
    full_duplex = fd; wide = w; lsb_first = lsb; clk_sel = 3'b111;
    irq_delay = 1; repeat_mode = 0;
    if (fd) begin tx_data = txd; tx_wr = 1; end else rx_rd = 1;
    @(negedge clk);
    tx_wr = 0; rx_rd = 0;
    for (int k = 0; k < len; k++) begin
      sck_in = 0; sdi_s = pat[bidx(len, lsb, k)];
      repeat (3) @(negedge clk);
      cap[bidx(len, lsb, k)] = sdo;
      if (sck_out !== 1'b1) sck_moved = 1;
      sck_in = 1;
      if (k < len - 1) repeat (3) @(negedge clk);
      else begin
        @(negedge clk);
        check(irq === 1'b1, "R8 slave irq undelayed", irq, 1);
      end
    end
    check(!sck_moved, "R8 sck_out held high in slave", sck_moved, 0);
    check(rx_data === fmask(pat, w), "R8 slave rx data", rx_data, fmask(pat, w));
    check(cap === (fd ? fmask(txd, w) : 16'h0), "R8 slave tx data", cap,
          fd ? fmask(txd, w) : 16'h0);
    @(negedge clk);
    check(busy === 1'b0, "R9 slave idle", busy, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && irq === 0 && rx_data === 0 && sck_out === 1 && sdo === 0,
          "R1 reset state", {busy, irq, sck_out, sdo}, 4'b0010);

    run_master(1, 0, 0, 0, 0, 16'h00A5, 16'h003C, 0);
    run_master(1, 1, 1, 1, 0, 16'hC3A1, 16'h5A0F, 0);
    run_master(1, 1, 0, 2, 1, 16'h8001, 16'h7FFE, 0);
    run_master(0, 0, 1, 1, 0, 16'hFFFF, 16'h0096, 0);
    run_master(1, 1, 0, 2, 0, 16'h1234, 16'hABCD, 1);

    for (int i = 0; i < 14; i++) begin
      logic [15:0] t = 16'($urandom);
      logic [15:0] p = 16'($urandom);
      run_master(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4),
                 1'($urandom), t, p, 0);
    end

    run_slave(1, 0, 0, 16'h00C9, 16'h0053);
    run_slave(0, 1, 1, 16'hFFFF, 16'hE71B);

    // R10 repeat frames
    @(negedge clk);
    full_duplex = 1; wide = 0; lsb_first = 0; clk_sel = 1; irq_delay = 0; repeat_mode = 1;
    m_len = 8; m_lsb = 0; m_pat = 16'h0042; m_k = 0; m_cap = 0; m_done = 0; m_on = 1;
    tx_data = 16'h0071; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    n = 0;
    while (irq !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    check(busy === 1'b1, "R10 busy across frames", busy, 1);
    check(m_done === 16'h0071, "R10 first frame data", m_done, 16'h0071);
    tx_data = 16'h00B4; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    n = 0;
    while (irq !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    check(n > 0 && n < 5000, "R10 second frame irq", n, 31);
    check(m_done === 16'h0071, "R10 second frame reuses buffer", m_done, 16'h0071);
    repeat_mode = 0;
    @(negedge clk);
    n = 0;
    while (irq !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    check(m_done === 16'h00B4, "R10 third frame new buffer", m_done, 16'h00B4);
    @(negedge clk);
    check(busy === 1'b0, "R10 stops after repeat cleared", busy, 0);
    m_on = 0;

    // R1 enable drop mid-frame
    @(negedge clk);
    full_duplex = 1; wide = 1; clk_sel = 3; tx_data = 16'hFFFF; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    repeat (30) @(negedge clk);
    check(busy === 1'b1, "R1 busy before disable", busy, 1);
    en = 0;
    #1;
    check(busy === 0 && irq === 0 && sck_out === 1 && sdo === 0 && rx_data === 0,
          "R1 async disable", {busy, irq, sck_out, sdo}, 4'b0010);
    @(negedge clk);
    en = 1;
    repeat (20) @(negedge clk);
    check(busy === 0 && irq === 0, "R1 stays idle after enable", {busy, irq}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule